// File: doc/BRIEF.md
# SPI Slave Hold Gate Controller

This block sits between the pins of a serial memory slave and its internal shift engine. It lets the bus master pause a transfer with an active-low hold pin and resume it later without losing any bits. While paused, the data output driver is released and activity on the serial clock and data-in pins is ignored. An internal program, erase or status-write cycle keeps running throughout.

All pin inputs are brought into a faster system clock domain through two-flop synchronizers, and edges are found from the synchronized values. A three-state controller (active, pending, paused) lets pause entry and exit take effect only while the synchronized serial clock is low. A hold edge seen while the clock is high is carried over to the next low phase. If the chip is deselected while paused, the front end is wiped. The controller then refuses traffic until the hold pin has been seen high while deselected and the chip is selected again. A stub shift register receives bytes, most significant bit first, so that pausing and resuming can be observed.

Top module: `hold_gate_ctrl`

## Requirements
- R1: A hold-pin falling edge enters the paused state only while chip select is low; a falling edge while deselected has no effect, and selecting afterwards with the hold pin still low leaves shifting and output enable working.
- R2: A hold-pin falling edge while the serial clock is low pauses within 3 system cycles; if the clock is high at that edge, the pause begins only after the clock next goes low.
- R3: A hold-pin rising edge while the serial clock is low ends the pause within 3 system cycles; if the clock is high, the pause ends only after the clock next goes low.
- R4: `sdoOe` is 0 while paused, while deselected and after reset, and 1 when selected, not paused and not locked out.
- R5: While paused, serial clock and data-in are ignored: `bitPos` and the partial word are frozen, so a byte split by a pause is received intact in `rxByte` (first bit received lands in bit 7).
- R6: `busyOut` equals `busyIn` at all times, whether paused or not.
- R7: Deselecting while paused gives a one-cycle `feReset` pulse, and `bitPos`, the partial word and `rxByte` all return to 0.
- R8: After an R7 reset, shifting and `sdoOe` stay disabled until the hold pin is seen high while deselected and chip select then falls; raising the hold pin while still selected does not unlock.
- R9: A deselect outside the paused state clears `bitPos` only; `rxByte` is kept and no `feReset` pulse occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, idles low, data sampled on rising edge |
| sdi | input | 1 | Serial data in |
| holdN | input | 1 | Hold pin, active low |
| busyIn | input | 1 | Internal write/program/erase cycle busy |
| shiftEn | output | 1 | Qualified one-cycle shift strobe to the shift engine |
| sdoOe | output | 1 | Output enable for serial data out (0 = high impedance) |
| feReset | output | 1 | One-cycle front-end reset pulse |
| busyOut | output | 1 | Busy indication passed through |
| bitPos | output | $clog2(WORD_BITS) | Bits received of the current word |
| rxByte | output | WORD_BITS | Last complete received word |

## Verification
A pin change reaches the synchronizer output after two system cycles, and the controller state moves on the third edge. `sdoOe`, `bitPos` and `rxByte` therefore settle within three cycles, and `busyOut` follows at once. The bench samples on falling system-clock edges six cycles after each pin change, and it holds every serial clock phase for eight cycles. Every sample therefore falls after the result is due and before the next stimulus. The one-cycle `feReset` pulse is counted by a monitor on every cycle, and that count is compared after each deselect.

// File: rtl/hold_pkg.sv
package hold_pkg;

  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'd0,
    ST_PENDING = 2'd1,
    ST_HOLD    = 2'd2
  } holdState_e;

  // strobes from the controller to the shift datapath
  typedef struct packed {
    logic shift;   // take one bit
    logic clear;   // chip deselected: restart word
    logic wipe;    // front-end reset after deselect in hold
  } shiftCtl_t;

endpackage

// File: rtl/hold_sync.sv
module hold_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int CHAIN_W = WIDTH * STAGES;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RST_VAL}};
    else       chain <= {chain[CHAIN_W-WIDTH-1:0], din};
  end

  assign dout = chain[CHAIN_W-1 -: WIDTH];

  initial begin
    assert (STAGES >= 2) else $error("hold_sync needs at least two stages");
  end
endmodule

// File: rtl/hold_ctrl.sv
module hold_ctrl
  import hold_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sckS,
  input  logic      csNS,
  input  logic      holdNS,
  output shiftCtl_t ctl,
  output logic      sdoOe,
  output logic      feReset
);
  holdState_e stateQ, stateD;
  logic awaitQ, awaitD;
  logic sckQ, holdNQ;
  logic wipeD, feResetQ;
  logic sckRise, holdFall, live;

  assign sckRise  = sckS & ~sckQ;
  assign holdFall = holdNQ & ~holdNS;

  always_comb begin
    stateD = stateQ;
    awaitD = awaitQ;
    wipeD  = 1'b0;
    // lockout clears once hold is seen high while deselected
    if (awaitQ && csNS && holdNS) awaitD = 1'b0;
    unique case (stateQ)
      ST_ACTIVE: begin
        if (!csNS && !awaitQ && holdFall)
          stateD = sckS ? ST_PENDING : ST_HOLD;
      end
      ST_PENDING: begin
        if (csNS || holdNS) stateD = ST_ACTIVE;
        else if (!sckS)     stateD = ST_HOLD;
      end
      ST_HOLD: begin
        if (csNS) begin
          stateD = ST_ACTIVE;
          awaitD = 1'b1;
          wipeD  = 1'b1;
        end else if (holdNS && !sckS) begin
          stateD = ST_ACTIVE;
        end
      end
      default: stateD = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_ACTIVE;
      awaitQ   <= 1'b0;
      sckQ     <= 1'b0;
      holdNQ   <= 1'b1;
      feResetQ <= 1'b0;
    end else begin
      stateQ   <= stateD;
      awaitQ   <= awaitD;
      sckQ     <= sckS;
      holdNQ   <= holdNS;
      feResetQ <= wipeD;
    end
  end

  assign live      = !csNS && (stateQ != ST_HOLD) && !awaitQ;
  assign ctl.shift = sckRise && live;
  assign ctl.clear = csNS;
  assign ctl.wipe  = feResetQ;
  assign sdoOe     = live;
  assign feReset   = feResetQ;

  // R1: no way out of ACTIVE while deselected
  p_enter_needs_sel_r1: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ACTIVE && csNS) |=> stateQ == ST_ACTIVE);

  // R2: pause never starts from a cycle with serial clock high
  p_enter_sck_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ != ST_HOLD && sckS) |=> stateQ != ST_HOLD);

  // R3: selected pause never ends from a cycle with serial clock high
  p_exit_sck_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_HOLD && sckS && !csNS) |=> stateQ == ST_HOLD);

  // R7: deselect in hold leads to a reset pulse and lockout
  p_deselect_wipe_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_HOLD && csNS) |=> (feReset && awaitQ));

  // R8: lockout persists while the hold pin stays low
  p_lock_holds_r8: assert property (@(posedge clk) disable iff (!rstN)
    (awaitQ && !holdNS) |=> awaitQ);
endmodule

// File: rtl/hold_shift.sv
module hold_shift
  import hold_pkg::*;
#(
  parameter int WORD_BITS = 8,
  localparam int CNT_W = $clog2(WORD_BITS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  shiftCtl_t            ctl,
  input  logic                 sdiS,
  output logic [CNT_W-1:0]     bitPos,
  output logic [WORD_BITS-1:0] rxByte
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_BITS - 1);

  logic [CNT_W-1:0]     bitCnt;
  logic [WORD_BITS-1:0] shReg, shNext;

  assign shNext = {shReg[WORD_BITS-2:0], sdiS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      shReg  <= '0;
      rxByte <= '0;
    end else if (ctl.wipe) begin
      bitCnt <= '0;
      shReg  <= '0;
      rxByte <= '0;
    end else if (ctl.clear) begin
      bitCnt <= '0;
    end else if (ctl.shift) begin
      shReg <= shNext;
      if (bitCnt == LAST) begin
        bitCnt <= '0;
        rxByte <= shNext;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  assign bitPos = bitCnt;

  // R5: without a strobe the partial word is frozen
  p_freeze_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.shift && !ctl.clear && !ctl.wipe) |=> ($stable(bitCnt) && $stable(shReg)));

  // R9: a plain deselect keeps the last received word
  p_keep_word_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.clear && !ctl.wipe) |=> $stable(rxByte));
endmodule

// File: rtl/hold_gate_ctrl.sv
module hold_gate_ctrl
  import hold_pkg::*;
#(
  parameter int WORD_BITS = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = $clog2(WORD_BITS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csN,
  input  logic                 sck,
  input  logic                 sdi,
  input  logic                 holdN,
  input  logic                 busyIn,
  output logic                 shiftEn,
  output logic                 sdoOe,
  output logic                 feReset,
  output logic                 busyOut,
  output logic [CNT_W-1:0]     bitPos,
  output logic [WORD_BITS-1:0] rxByte
);
  localparam int PIN_W = 4;
  localparam logic [PIN_W-1:0] PIN_RST = 4'b1100; // csN, holdN idle high

  logic [PIN_W-1:0] pinsS;
  logic csNS, holdNS, sckS, sdiS;
  shiftCtl_t ctl;

  hold_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk(clk), .rstN(rstN), .din({csN, holdN, sck, sdi}), .dout(pinsS)
  );

  assign {csNS, holdNS, sckS, sdiS} = pinsS;

  hold_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sckS(sckS), .csNS(csNS), .holdNS(holdNS),
    .ctl(ctl), .sdoOe(sdoOe), .feReset(feReset)
  );

  hold_shift #(.WORD_BITS(WORD_BITS)) u_shift (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sdiS(sdiS),
    .bitPos(bitPos), .rxByte(rxByte)
  );

  assign shiftEn = ctl.shift;
  assign busyOut = busyIn;   // R6: internal cycles are never interrupted

  // R4: output driver released while deselected
  p_oe_off_desel_r4: assert property (@(posedge clk) disable iff (!rstN)
    csNS |-> !sdoOe);
endmodule

// File: tb/tb_hold_gate_ctrl.sv
module tb_hold_gate_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam int SETTLE = 6;

  logic clk = 1'b0, rstN = 1'b0;
  logic csN = 1'b1, sck = 1'b0, sdi = 1'b0, holdN = 1'b1, busyIn = 1'b0;
  logic shiftEn, sdoOe, feReset, busyOut;
  logic [2:0] bitPos;
  logic [7:0] rxByte;

  int nVec = 0, nBad = 0, feCount = 0, expPos = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hold_gate_ctrl dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .sdi(sdi), .holdN(holdN),
    .busyIn(busyIn), .shiftEn(shiftEn), .sdoOe(sdoOe), .feReset(feReset),
    .busyOut(busyOut), .bitPos(bitPos), .rxByte(rxByte)
  );

  always @(posedge clk) if (rstN && feReset) feCount <= feCount + 1;

  // expected output enable from the requirements (R4, R8)
  function automatic int expOe(bit selected, bit paused, bit locked);
    return (selected && !paused && !locked) ? 1 : 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sckPulse(bit d);
    sdi = d;
    waitClk(HALF);
    sck = 1'b1;
    waitClk(HALF);
    sck = 1'b0;
  endtask

  task automatic noise();
    for (int i = 0; i < 3; i++) begin
      busyIn = 1'($urandom);
      sckPulse(1'($urandom));
      chk("R6 busy passthrough in hold", busyOut, busyIn);
    end
    waitClk(SETTLE);
    chk("R5 bitPos frozen in hold", bitPos, expPos);
    chk("R4 oe off in hold", sdoOe, expOe(1, 1, 0));
  endtask

  task automatic holdExit(bit viaHigh);
    if (viaHigh) begin
      sck = 1'b1;
      waitClk(SETTLE);
      holdN = 1'b1;
      waitClk(SETTLE);
      chk("R3 exit deferred while sck high", sdoOe, 0);
      sck = 1'b0;
      waitClk(SETTLE);
      chk("R3 exit after sck low", sdoOe, 1);
    end else begin
      holdN = 1'b1;
      waitClk(SETTLE);
      chk("R3 exit with sck low", sdoOe, 1);
    end
  endtask

  task automatic xferByte(logic [7:0] b, int pos, bit entryHigh, bit exitHigh, bit doHold);
    csN = 1'b0;
    waitClk(SETTLE);
    for (int k = 0; k < 8; k++) begin
      if (doHold && k == pos && !entryHigh) begin
        expPos = k;
        holdN = 1'b0;
        waitClk(SETTLE);
        chk("R2 entry with sck low", sdoOe, 0);
        noise();
        holdExit(exitHigh);
        sckPulse(b[7-k]);
      end else if (doHold && k == pos) begin
        sdi = b[7-k];
        waitClk(HALF);
        sck = 1'b1;
        waitClk(SETTLE);
        holdN = 1'b0;
        waitClk(SETTLE);
        chk("R2 entry deferred while sck high", sdoOe, 1);
        sck = 1'b0;
        waitClk(SETTLE);
        chk("R2 entry after sck low", sdoOe, 0);
        expPos = (k + 1) % 8;
        noise();
        holdExit(exitHigh);
      end else begin
        sckPulse(b[7-k]);
      end
    end
    waitClk(SETTLE);
    chk("R5 byte across hold intact", rxByte, b);
    chk("R5 bitPos after byte", bitPos, 0);
    csN = 1'b1;
    waitClk(SETTLE);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: got 0 expected 1 (run completed)");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    int fe0;
    logic [7:0] keep;
    void'($urandom(32'h5EED));
    waitClk(3);
    rstN = 1'b1;
    waitClk(SETTLE);
    // reset state
    chk("R4 oe after reset", sdoOe, expOe(0, 0, 0));
    chk("R7 no reset pulse after reset", feCount, 0);
    chk("R5 bitPos after reset", bitPos, 0);
    chk("R5 rxByte after reset", rxByte, 0);

    // R1: hold edge while deselected is ignored
    holdN = 1'b0;
    waitClk(SETTLE);
    csN = 1'b0;
    waitClk(SETTLE);
    chk("R1 no hold from deselected edge", sdoOe, 1);
    sckPulse(1'b1);
    waitClk(SETTLE);
    chk("R1 shifting works", bitPos, 1);
    csN = 1'b1;
    holdN = 1'b1;
    waitClk(SETTLE);

    // directed corners: entry/exit phases
    xferByte(8'hA5, 3, 0, 0, 1);
    xferByte(8'h3C, 5, 1, 1, 1);
    xferByte(8'h81, 7, 1, 0, 1);
    xferByte(8'h7E, 0, 0, 1, 1);

    // random traffic
    for (int n = 0; n < 16; n++) begin
      xferByte(8'($urandom), int'($urandom_range(0, 7)), 1'($urandom),
               1'($urandom), 1'($urandom));
    end

    // R9: plain deselect mid-word
    keep = rxByte;
    fe0 = feCount;
    csN = 1'b0;
    waitClk(SETTLE);
    sckPulse(1); sckPulse(0); sckPulse(1);
    waitClk(SETTLE);
    chk("R9 partial bits counted", bitPos, 3);
    csN = 1'b1;
    waitClk(SETTLE);
    chk("R9 bitPos cleared", bitPos, 0);
    chk("R9 rxByte kept", rxByte, keep);
    chk("R9 no reset pulse", feCount, fe0);

    // R7 / R8: deselect during hold, then illegal reselect order
    csN = 1'b0;
    waitClk(SETTLE);
    sckPulse(1); sckPulse(0); sckPulse(1);
    holdN = 1'b0;
    waitClk(SETTLE);
    chk("R4 oe off in hold", sdoOe, 0);
    csN = 1'b1;
    waitClk(SETTLE);
    chk("R7 one reset pulse", feCount, fe0 + 1);
    chk("R7 bitPos cleared", bitPos, 0);
    chk("R7 rxByte cleared", rxByte, 0);
    csN = 1'b0;
    waitClk(SETTLE);
    chk("R8 locked with hold low", sdoOe, expOe(1, 0, 1));
    sckPulse(1);
    waitClk(SETTLE);
    chk("R8 no shift while locked", bitPos, 0);
    holdN = 1'b1;
    waitClk(SETTLE);
    chk("R8 hold high while selected does not unlock", sdoOe, 0);
    csN = 1'b1;
    waitClk(SETTLE);
    chk("R8 still no extra reset", feCount, fe0 + 1);
    xferByte(8'hC3, 2, 0, 0, 1);
    chk("R8 unlocked after proper order", rxByte, 8'hC3);

    // R6 outside hold
    busyIn = 1'b1;
    waitClk(1);
    chk("R6 busy passthrough", busyOut, 1);
    busyIn = 1'b0;
    waitClk(1);
    chk("R6 busy passthrough", busyOut, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule